// File: doc/BRIEF.md
# Two-Byte-Address Serial Memory Read Sequencer

This block is a bus master for the two-wire serial bus. It fetches bytes from a memory device that takes a 16-bit word address. A single start pulse launches one transaction. The transaction uses the latched device address, word address, byte count and mode. Three modes are supported:

- **Random read.** A dummy write carries the two address bytes, then a repeated start turns the bus around for reading.
- **Address load.** The same dummy write is closed by a stop, so the device pointer is set and nothing is read.
- **Current-pointer read.** The address write is skipped and reading starts at wherever the device pointer already is.

Received bytes leave on a valid/ready stream. While a byte waits for its consumer, the block holds the clock line low, so the bus stalls rather than losing data. A missing acknowledge on any address byte ends the transfer with a stop and an error indication. Both bus lines are open-drain: an output-enable of 1 pulls the line low, and an output-enable of 0 releases it. Bus timing comes from the system clock through a divider.

Top module: `eeprom_rd_seq`

## Requirements
- R1: While reset is asserted and after its release, with no start pulse, both output-enables are 0 and `busy_o`, `done_o` and `rd_valid_o` are 0.
- R2: With `mode_i` = 2'b00 (random read), the bus carries the following, in order:
  - a start condition;
  - the byte {dev,0};
  - the word address high byte, then the low byte;
  - a repeated start;
  - the byte {dev,1};
  - the data phase.
  
  The device must acknowledge each address byte.
- R3: With `mode_i` = 2'b01 (address load), a stop follows the acknowledged low address byte. No data byte is read and `rd_valid_o` never rises.
- R4: With `mode_i[1]` = 1 (current-pointer read), the bus carries a start and the byte {dev,1}, then the data phase, with no word address bytes.
- R5: Exactly `len_m1_i`+1 bytes are read. The master acknowledges (SDA low) every byte except the last. The last byte gets a no-acknowledge (SDA released), followed by a stop.
- R6: Bits on the bus are MSB first in both directions. `rd_data_o` equals the byte the device sent.
- R7: SDA changes while SCL is high only to form a start (SDA falling) or a stop (SDA rising). Start and stop conditions appear only where R2 to R5 and R8 place them.
- R8: If an address byte is not acknowledged, the master issues a stop at once. It reads no data, and `err_o` is 1 in the `done_o` cycle.
- R9: A byte on the stream stays valid with stable data until `rd_ready_i` is 1. Throughout that wait SCL is held low.
- R10:
  - `busy_o` is 1 from the cycle after an accepted start pulse until the transaction ends.
  - `done_o` pulses once per transaction, with both lines released.
  - A start pulse while busy is ignored.
- R11: Every SCL high phase, except the idle level after a stop or reset, lasts exactly `HALF_CYC` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a transaction |
| mode_i | input | 2 | 00 random read, 01 address load, 1x current-pointer read |
| dev_addr_i | input | 7 | Device address |
| word_addr_i | input | 16 | Word address for modes 00 and 01 |
| len_m1_i | input | LEN_W | Number of bytes to read minus one |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| err_o | output | 1 | Address byte was not acknowledged (valid with done_o) |
| rd_data_o | output | 8 | Received byte |
| rd_valid_o | output | 1 | rd_data_o holds a byte |
| rd_ready_i | input | 1 | Consumer accepts the byte |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sensed level of the SDA line |

## Verification
The bench attaches a behavioural memory device that decodes the bus. Its bus log and the stream output are compared against sequences derived from the requirements. The transactions used are:

- A multi-byte random read under a sparse ready pattern, which separates correct per-byte acknowledge and stall handling from premature clocking.
- An address load followed by a single-byte current-pointer read, which shows that the stop-terminated write moved the device pointer and that the read path skips the address bytes.
- Injected missing acknowledges on a word address byte and on the read address byte, which distinguish the abort path from normal completion.
- A run with a second start pulse issued mid-transfer, which checks that requests while busy are ignored.

// File: rtl/eeprom_rd_pkg.sv
`timescale 1ns/1ps
package eeprom_rd_pkg;

  // Bus-level primitives handed to the bit engine
  typedef enum logic [1:0] {
    BC_START = 2'd0,
    BC_STOP  = 2'd1,
    BC_WBIT  = 2'd2,
    BC_RBIT  = 2'd3
  } bus_cmd_e;

  // Transaction sequencer states
  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_START,
    SQ_TXBYTE,
    SQ_RXACK,
    SQ_RXBYTE,
    SQ_HOLD,
    SQ_TXACK,
    SQ_STOP,
    SQ_FIN
  } seq_state_e;

  // Byte slots sent by the master
  localparam logic [1:0] SEL_DEVW = 2'd0;
  localparam logic [1:0] SEL_AHI  = 2'd1;
  localparam logic [1:0] SEL_ALO  = 2'd2;
  localparam logic [1:0] SEL_DEVR = 2'd3;

endpackage

// File: rtl/i2c_bit_phy.sv
`timescale 1ns/1ps
module i2c_bit_phy
  import eeprom_rd_pkg::*;
#(
  parameter int HALF_CYC = 250
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_valid_i,
  input  bus_cmd_e cmd_i,
  input  logic     cmd_bit_i,
  output logic     cmd_done_o,
  output logic     rx_bit_o,
  output logic     scl_oe_o,
  output logic     sda_oe_o,
  input  logic     sda_i
);

  localparam int QTR = HALF_CYC / 2;
  localparam int QW  = (QTR > 1) ? $clog2(QTR) : 1;
  localparam logic [QW-1:0] QLAST = QW'(QTR - 1);

  logic          active_q, active_d;
  logic [1:0]    qtr_q, qtr_d;
  logic [QW-1:0] cnt_q, cnt_d;
  bus_cmd_e      cmd_q, cmd_d;
  logic          bit_q, bit_d;
  logic          scl_lo_q, scl_lo_d;
  logic          sda_lo_q, sda_lo_d;
  logic          rx_q, rx_d;
  logic [1:0]    sync_q;
  logic          qend;

  // {pull SCL low, pull SDA low} for each quarter of a primitive
  function automatic logic [1:0] drive_of(bus_cmd_e c, logic b, logic [1:0] q);
    logic [1:0] r;
    case (c)
      BC_START: case (q)
                  2'd0:    r = 2'b10;
                  2'd1:    r = 2'b00;
                  2'd2:    r = 2'b01;
                  default: r = 2'b11;
                endcase
      BC_STOP:  case (q)
                  2'd0:    r = 2'b11;
                  2'd1:    r = 2'b01;
                  default: r = 2'b00;
                endcase
      BC_WBIT:  r = {~q[1], ~b};
      default:  r = {~q[1], 1'b0};
    endcase
    return r;
  endfunction

  assign qend       = active_q && (cnt_q == QLAST);
  assign cmd_done_o = qend && (qtr_q == 2'd3);
  assign rx_bit_o   = rx_q;
  assign scl_oe_o   = scl_lo_q;
  assign sda_oe_o   = sda_lo_q;

  always_comb begin
    active_d = active_q;
    qtr_d    = qtr_q;
    cnt_d    = cnt_q;
    cmd_d    = cmd_q;
    bit_d    = bit_q;
    scl_lo_d = scl_lo_q;
    sda_lo_d = sda_lo_q;
    rx_d     = rx_q;
    if (!active_q) begin
      if (cmd_valid_i) begin
        active_d = 1'b1;
        qtr_d    = 2'd0;
        cnt_d    = '0;
        cmd_d    = cmd_i;
        bit_d    = cmd_bit_i;
        {scl_lo_d, sda_lo_d} = drive_of(cmd_i, cmd_bit_i, 2'd0);
      end
    end else if (qend) begin
      cnt_d = '0;
      if (qtr_q == 2'd2) rx_d = sync_q[1];   // middle of SCL high
      if (qtr_q == 2'd3) begin
        active_d = 1'b0;
        if (cmd_q != BC_STOP) scl_lo_d = 1'b1; // park with SCL low
      end else begin
        qtr_d = qtr_q + 2'd1;
        {scl_lo_d, sda_lo_d} = drive_of(cmd_q, bit_q, qtr_q + 2'd1);
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      qtr_q    <= 2'd0;
      cnt_q    <= '0;
      cmd_q    <= BC_STOP;
      bit_q    <= 1'b0;
      scl_lo_q <= 1'b0;
      sda_lo_q <= 1'b0;
      rx_q     <= 1'b1;
      sync_q   <= 2'b11;
    end else begin
      active_q <= active_d;
      qtr_q    <= qtr_d;
      cnt_q    <= cnt_d;
      cmd_q    <= cmd_d;
      bit_q    <= bit_d;
      scl_lo_q <= scl_lo_d;
      sda_lo_q <= sda_lo_d;
      rx_q     <= rx_d;
      sync_q   <= {sync_q[0], sda_i};
    end
  end

  // R7
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_lo_q && !$past(scl_lo_q) && (sda_lo_q != $past(sda_lo_q)))
      |-> (cmd_q == BC_START || cmd_q == BC_STOP));

endmodule

// File: rtl/eeprom_rd_seq.sv
`timescale 1ns/1ps
module eeprom_rd_seq
  import eeprom_rd_pkg::*;
#(
  parameter int HALF_CYC = 250,
  parameter int LEN_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [6:0]       dev_addr_i,
  input  logic [15:0]      word_addr_i,
  input  logic [LEN_W-1:0] len_m1_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  input  logic             sda_i
);

  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  seq_state_e       st_q, st_d;
  logic             cur_q, cur_d, seta_q, seta_d, err_q, err_d;
  logic [6:0]       dev_q, dev_d;
  logic [15:0]      wa_q, wa_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [1:0]       sel_q, sel_d;
  logic [2:0]       bcnt_q, bcnt_d;
  logic [7:0]       sh_q, sh_d;

  logic     cmd_valid, cmd_bit, cmd_done, rx_bit;
  bus_cmd_e cmd;

  function automatic logic [7:0] byte_of(logic [1:0] s, logic [6:0] d, logic [15:0] w);
    logic [7:0] r;
    case (s)
      SEL_DEVW: r = {d, 1'b0};
      SEL_AHI:  r = w[15:8];
      SEL_ALO:  r = w[7:0];
      default:  r = {d, 1'b1};
    endcase
    return r;
  endfunction

  i2c_bit_phy #(.HALF_CYC(HALF_CYC)) phy_i (
    .clk         (clk),
    .rst_n       (rst_ni),
    .cmd_valid_i (cmd_valid),
    .cmd_i       (cmd),
    .cmd_bit_i   (cmd_bit),
    .cmd_done_o  (cmd_done),
    .rx_bit_o    (rx_bit),
    .scl_oe_o    (scl_oe_o),
    .sda_oe_o    (sda_oe_o),
    .sda_i       (sda_i)
  );

  always_comb begin
    st_d = st_q;  cur_d = cur_q;  seta_d = seta_q;  err_d = err_q;
    dev_d = dev_q;  wa_d = wa_q;  left_d = left_q;  sel_d = sel_q;
    bcnt_d = bcnt_q;  sh_d = sh_q;
    cmd_valid = 1'b0;  cmd = BC_START;  cmd_bit = 1'b0;
    case (st_q)
      SQ_IDLE: if (start_i) begin
        cur_d  = mode_i[1];
        seta_d = !mode_i[1] && mode_i[0];
        dev_d  = dev_addr_i;
        wa_d   = word_addr_i;
        left_d = len_m1_i;
        sel_d  = mode_i[1] ? SEL_DEVR : SEL_DEVW;
        err_d  = 1'b0;
        st_d   = SQ_START;
      end
      SQ_START: begin
        cmd_valid = 1'b1;
        cmd       = BC_START;
        if (cmd_done) begin
          sh_d   = byte_of(sel_q, dev_q, wa_q);
          bcnt_d = 3'd0;
          st_d   = SQ_TXBYTE;
        end
      end
      SQ_TXBYTE: begin
        cmd_valid = 1'b1;
        cmd       = BC_WBIT;
        cmd_bit   = sh_q[7];
        if (cmd_done) begin
          sh_d   = {sh_q[6:0], 1'b0};
          bcnt_d = bcnt_q + 3'd1;
          if (bcnt_q == 3'd7) st_d = SQ_RXACK;
        end
      end
      SQ_RXACK: begin
        cmd_valid = 1'b1;
        cmd       = BC_RBIT;
        if (cmd_done) begin
          bcnt_d = 3'd0;
          if (rx_bit) begin
            err_d = 1'b1;
            st_d  = SQ_STOP;
          end else if (sel_q == SEL_DEVR) begin
            st_d = SQ_RXBYTE;
          end else if (sel_q == SEL_ALO) begin
            sel_d = SEL_DEVR;
            st_d  = seta_q ? SQ_STOP : SQ_START;
          end else begin
            sel_d = sel_q + 2'd1;
            sh_d  = byte_of(sel_q + 2'd1, dev_q, wa_q);
            st_d  = SQ_TXBYTE;
          end
        end
      end
      SQ_RXBYTE: begin
        cmd_valid = 1'b1;
        cmd       = BC_RBIT;
        if (cmd_done) begin
          sh_d   = {sh_q[6:0], rx_bit};
          bcnt_d = bcnt_q + 3'd1;
          if (bcnt_q == 3'd7) st_d = SQ_HOLD;
        end
      end
      SQ_HOLD: if (rd_ready_i) st_d = SQ_TXACK;
      SQ_TXACK: begin
        cmd_valid = 1'b1;
        cmd       = BC_WBIT;
        cmd_bit   = (left_q == '0);
        if (cmd_done) begin
          bcnt_d = 3'd0;
          if (left_q == '0) st_d = SQ_STOP;
          else begin
            left_d = left_q - LEN_W'(1);
            st_d   = SQ_RXBYTE;
          end
        end
      end
      SQ_STOP: begin
        cmd_valid = 1'b1;
        cmd       = BC_STOP;
        if (cmd_done) st_d = SQ_FIN;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SQ_IDLE;  cur_q <= 1'b0;  seta_q <= 1'b0;  err_q <= 1'b0;
      dev_q <= '0;  wa_q <= '0;  left_q <= '0;  sel_q <= SEL_DEVW;
      bcnt_q <= '0;  sh_q <= '0;
    end else begin
      st_q <= st_d;  cur_q <= cur_d;  seta_q <= seta_d;  err_q <= err_d;
      dev_q <= dev_d;  wa_q <= wa_d;  left_q <= left_d;  sel_q <= sel_d;
      bcnt_q <= bcnt_d;  sh_q <= sh_d;
    end
  end

  assign busy_o     = (st_q != SQ_IDLE);
  assign done_o     = (st_q == SQ_FIN);
  assign err_o      = (st_q == SQ_FIN) && err_q;
  assign rd_valid_o = (st_q == SQ_HOLD);
  assign rd_data_o  = sh_q;

  // R9
  hold_scl_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_valid_o |-> scl_oe_o);

  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

  // R10
  done_bus_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |-> (!scl_oe_o && !sda_oe_o));

  // R3
  seta_nodata_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    seta_q |-> !rd_valid_o);

endmodule

// File: tb/eeprom_rd_seq_tb_top.sv
`timescale 1ns/1ps
module eeprom_rd_seq_tb_top;

  localparam int HALF  = 4;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n, start, busy, done, err, rd_valid, rd_ready;
  logic [1:0]       mode;
  logic [6:0]       dev;
  logic [15:0]      wa;
  logic [LEN_W-1:0] len_m1;
  logic [7:0]       rd_data;
  logic             scl_oe, sda_oe, sda_line;
  bit               sl_drv;

  assign sda_line = !(sda_oe || sl_drv);

  eeprom_rd_seq #(.HALF_CYC(HALF), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
    .dev_addr_i(dev), .word_addr_i(wa), .len_m1_i(len_m1),
    .busy_o(busy), .done_o(done), .err_o(err), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_line)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_of(logic [15:0] a);
    return 8'(a[7:0] * 8'd7 + a[15:8] + 8'h3C);
  endfunction

  // ---------------- behavioural memory device ----------------
  // log codes: 0..255 byte from master, 256 start, 257 stop, 258 master ack, 259 master nack
  int          log_q[$];
  int          sst, bitn, nbyte, rxcount, nack_at;
  logic [7:0]  sh, txd;
  logic [15:0] ptr = 16'h0000;
  bit          rd_dir, ackv, scl_p, sda_p, hi_skip;
  int          hi_cnt;

  always @(negedge clk) begin
    bit sn, dn;
    sn = !scl_oe;
    dn = sda_line;
    if (!rst_n) begin
      sst = 0; sl_drv = 0; scl_p = 1; sda_p = 1; hi_skip = 1; hi_cnt = 0;
    end else begin
      if (scl_p && sn && sda_p && !dn) begin
        chk(sst != 4, "R7 start during device data", sst, 0);
        log_q.push_back(256); sst = 1; bitn = 0; nbyte = 0; sh = 0;
      end else if (scl_p && sn && !sda_p && dn) begin
        chk(sst != 4, "R7 stop during device data", sst, 0);
        log_q.push_back(257); sst = 0; hi_skip = 1;
      end else if (sn && !scl_p) begin
        hi_cnt = 0;
        case (sst)
          1: begin
            sh = {sh[6:0], dn}; bitn++;
            if (bitn == 8) begin
              log_q.push_back(int'(sh));
              ackv = (rxcount != nack_at); rxcount++;
              rd_dir = (nbyte == 0) && sh[0];
              if (nbyte == 1) ptr[15:8] = sh;
              if (nbyte == 2) ptr[7:0]  = sh;
              nbyte++; sst = 2;
            end
          end
          4: bitn++;
          5: begin
            log_q.push_back(dn ? 259 : 258);
            ptr++;
            if (!dn) begin txd = mem_of(ptr); bitn = 0; sst = 4; end
            else sst = 0;
          end
          default: ;
        endcase
      end else if (!sn && scl_p) begin
        if (!hi_skip) chk(hi_cnt == HALF, "R11 SCL high length", hi_cnt, HALF);
        hi_skip = 0;
        case (sst)
          2: begin sl_drv = ackv; sst = 3; end
          3: begin
            sl_drv = 0;
            if (!ackv) sst = 0;
            else if (rd_dir) begin
              txd = mem_of(ptr); bitn = 0; sst = 4; sl_drv = !txd[7];
            end else begin sst = 1; bitn = 0; sh = 0; end
          end
          4: if (bitn < 8) sl_drv = !txd[7 - bitn];
             else begin sl_drv = 0; sst = 5; end
          default: ;
        endcase
      end
      if (sn) hi_cnt++;
      scl_p = sn;
      sda_p = sda_line;
    end
  end

  // ---------------- stream and completion monitor ----------------
  int         got_q[$];
  int         done_cnt, cyc;
  bit         pv, pr, rdy_all, last_err;
  logic [7:0] pd;

  always @(negedge clk) begin
    if (!rst_n) begin
      pv = 0; pr = 0; rd_ready = 0; cyc = 0;
    end else begin
      if (pv && pr) got_q.push_back(int'(pd));
      if (rd_valid) chk(scl_oe == 1'b1, "R9 SCL held low while byte waits", scl_oe, 1);
      if (pv && !pr) chk(rd_valid && rd_data == pd, "R9 byte held until ready", rd_data, pd);
      if (done) begin
        done_cnt++;
        last_err = err;
        chk(!scl_oe && !sda_oe, "R10 bus released at done", {scl_oe, sda_oe}, 0);
      end
      rd_ready = rdy_all || (cyc % 5 == 0);
      pv = rd_valid; pr = rd_ready; pd = rd_data; cyc++;
    end
  end

  // ---------------- transaction driver ----------------
  task automatic run(input logic [1:0] m, input logic [6:0] dv, input logic [15:0] a,
                     input int n, input int nack, input bit ready_all, input bit poke,
                     input string tag);
    int  exp_log[$];
    int  exp_b[$];
    bit  ab;
    int  w;
    logic [15:0] p;
    ab = 0;
    exp_log.push_back(256);
    if (m[1] == 1'b0) begin
      exp_log.push_back({dv, 1'b0});
      if (nack == 0) ab = 1;
      if (!ab) begin exp_log.push_back(a[15:8]); if (nack == 1) ab = 1; end
      if (!ab) begin exp_log.push_back(a[7:0]);  if (nack == 2) ab = 1; end
      if (!ab && m[0]) begin exp_log.push_back(257); end
      if (!ab && !m[0]) exp_log.push_back(256);
    end
    if (!ab && !(m == 2'b01)) begin
      exp_log.push_back({dv, 1'b1});
      if (nack == (m[1] ? 0 : 3)) ab = 1;
      if (!ab) begin
        p = m[1] ? ptr : a;
        for (int i = 0; i < n; i++) begin
          exp_b.push_back(int'(mem_of(16'(p + i))));
          exp_log.push_back((i == n - 1) ? 259 : 258);
        end
        exp_log.push_back(257);
      end
    end
    if (ab) exp_log.push_back(257);

    log_q.delete(); got_q.delete();
    rxcount = 0; nack_at = nack; done_cnt = 0; rdy_all = ready_all;
    @(negedge clk);
    start = 1; mode = m; dev = dv; wa = a; len_m1 = LEN_W'(n - 1);
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, {tag, " R10 busy after start"}, busy, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1; mode = 2'b01; wa = 16'h0F0F;
      @(negedge clk);
      start = 0;
    end
    w = 0;
    while (done_cnt == 0 && w < 20000) begin @(negedge clk); w++; end
    repeat (30) @(negedge clk);
    chk(done_cnt == 1, {tag, " R10 one done pulse"}, done_cnt, 1);
    chk(busy == 1'b0, {tag, " R10 idle after done"}, busy, 0);
    chk(last_err == ab, {tag, " R8 error flag"}, last_err, ab);
    chk(log_q.size() == exp_log.size(), {tag, " R7 bus event count"}, log_q.size(), exp_log.size());
    for (int i = 0; i < exp_log.size() && i < log_q.size(); i++)
      chk(log_q[i] == exp_log[i], {tag, " R5 R7 bus event"}, log_q[i], exp_log[i]);
    chk(got_q.size() == exp_b.size(), {tag, " R5 byte count"}, got_q.size(), exp_b.size());
    for (int i = 0; i < exp_b.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_b[i], {tag, " R6 data MSB first"}, got_q[i], exp_b[i]);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; mode = 0; dev = 0; wa = 0; len_m1 = 0; nack_at = -1;
    rdy_all = 0; done_cnt = 0; last_err = 0;
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !rd_valid && !done, "R1 during reset",
        {scl_oe, sda_oe, busy, rd_valid, done}, 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !rd_valid && !done, "R1 after reset",
        {scl_oe, sda_oe, busy, rd_valid, done}, 0);

    run(2'b00, 7'h50, 16'h1234, 4, -1, 1'b0, 1'b0, "R2 random read");
    run(2'b01, 7'h51, 16'hABCD, 1, -1, 1'b1, 1'b0, "R3 address load");
    run(2'b10, 7'h50, 16'h0000, 1, -1, 1'b0, 1'b0, "R4 current read");
    run(2'b00, 7'h52, 16'h4321, 2,  1, 1'b1, 1'b0, "R8 nack on high address");
    run(2'b11, 7'h53, 16'h0000, 3,  0, 1'b1, 1'b0, "R8 nack on read address");
    run(2'b00, 7'h50, 16'hFFFE, 3, -1, 1'b1, 1'b1, "R10 start while busy");

    summary();
    $finish;
  end

endmodule